// File: doc/BRIEF.md
# Configurable Register Macrocell

One programmable logic cell. It registers a single logic input and drives one output that can be switched off. It also returns two feedback signals to the surrounding routing. Configuration bits set the cell's behaviour:

- whether the storage element acts as a D or a T flip-flop;
- which of two clock sources it follows, and on which edge of that source it updates;
- whether the control-term preset and reset are active;
- where the output enable comes from;
- whether a global three-state input is honoured;
- whether the output takes the registered value or the raw logic input.

Both cell clocks are ordinary signals sampled by one system clock. A cell clock "edge" is a change in the sampled level of the selected source. The register updates on the system clock edge at which the new level is first sampled. The design therefore has a single clock domain and stays synthesizable.

Source 0 is meant for an external clock. Source 1 may come from a pin or from internal logic.

The output is not driven as a bidirectional pad. It is split into a driven value, an enable and a sampled external value. The pin feedback shows what the pin carries: the driven value when the output is enabled, and the external value when it is not.

Top module: `prog_macrocell`

## Requirements
- R1: While `rst_ni` is low the register holds 0. After release it stays 0 until a clock edge or a control term changes it.
- R2: In D mode (`cfg_ttype_i`=0), a selected edge loads `d_i` into the register. The load shows on `reg_fb_o` right after the system clock edge at which the new source level is first sampled.
- R3: In T mode (`cfg_ttype_i`=1), a selected edge inverts the register when `d_i`=1 and leaves it unchanged when `d_i`=0.
- R4: `cfg_clksel_i`=0 makes the cell follow `clk_src_i[0]`, and 1 makes it follow `clk_src_i[1]`. Edges on the source that is not selected have no effect.
- R5: `cfg_fall_i`=0 selects rising edges (0 to 1) and `cfg_fall_i`=1 selects falling edges (1 to 0). The opposite edge has no effect.
- R6: With `cfg_ctl_en_i`=1, `ctl_i[0]`=1 sets the register and `ctl_i[1]`=1 clears it, with no cell clock edge needed. The change is visible after the next system clock edge. With `cfg_ctl_en_i`=0 both bits are ignored.
- R7: When `ctl_i[0]` and `ctl_i[1]` are both 1 and control terms are enabled, the register clears.
- R8: The local enable follows `cfg_oe_sel_i`. Codes 0 to 3 select `ctl_i[2+code]`, code 4 is always on, and codes 5, 6 and 7 are always off.
- R9: With `cfg_gts_en_i`=1 and `gts_ni`=0, `pad_oe_o` is 0 whatever the local enable. With `cfg_gts_en_i`=0, `gts_ni` is ignored.
- R10: With `cfg_bypass_i`=1, `pad_o` follows `d_i` combinationally. The register keeps working as configured.
- R11: `reg_fb_o` always carries the register value, whatever the bypass and enable settings.
- R12: `pin_fb_o` equals `pad_o` when `pad_oe_o`=1 and equals `pad_in_i` when `pad_oe_o`=0.
- R13: Each clock source keeps its own sampled history. Changing `cfg_clksel_i` or `cfg_fall_i` therefore never by itself produces an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low power-on reset |
| cfg_ttype_i | input | 1 | 1 = T flip-flop, 0 = D flip-flop |
| cfg_clksel_i | input | SEL_W (1) | Clock source select |
| cfg_fall_i | input | 1 | 1 = falling edge, 0 = rising edge |
| cfg_ctl_en_i | input | 1 | Enables the preset/reset control terms |
| cfg_oe_sel_i | input | OE_SEL_W (3) | Output-enable source code |
| cfg_bypass_i | input | 1 | Output takes the logic input directly |
| cfg_gts_en_i | input | 1 | Honour the global three-state input |
| clk_src_i | input | NUM_CLK (2) | Cell clock sources as sampled levels |
| d_i | input | 1 | Logic input |
| ctl_i | input | CT_W (6) | Control terms: [0] preset, [1] reset, [5:2] enable candidates |
| gts_ni | input | 1 | Global three-state, active low |
| pad_in_i | input | 1 | Value present on the pin from outside |
| pad_o | output | 1 | Value driven to the pin |
| pad_oe_o | output | 1 | Output driver enable |
| reg_fb_o | output | 1 | Register feedback |
| pin_fb_o | output | 1 | Pin feedback |

## Verification
The assertions assume several things about the inputs:

- Every input changes only between system clock edges.
- Each clock-source level is held for at least one whole system cycle, so no edge can be missed.
- The sources are low while reset is asserted.

The checker keeps its own record of the previous source levels and only trusts it from the second cycle after reset. The stimulus drives all inputs on the falling system edge and moves each source one level per step. It also switches the source and polarity selection while the two sources sit at different levels, which exercises R13.

// File: rtl/prog_macrocell_pkg.sv
`timescale 1ns/1ps
package prog_macrocell_pkg;
    // Default shape of one cell
    localparam int MC_NUM_CLK = 2;
    localparam int MC_NUM_OE  = 4;

    // Control-term bit positions (neighbouring product-term logic decodes these)
    localparam int MC_PRESET_BIT = 0;
    localparam int MC_RESET_BIT  = 1;
    localparam int MC_OE_BASE    = 2;
endpackage

// File: rtl/mc_edge_pick.sv
`timescale 1ns/1ps
module mc_edge_pick #(
    parameter int NUM_CLK = 2,
    localparam int SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_CLK-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               fall_i,
    output logic               fire_o
);
    typedef struct packed {
        logic [NUM_CLK-1:0] lvl;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [NUM_CLK-1:0] rise_v, drop_v;

    // one detector per source, so switching selection never fakes an edge
    for (genvar g = 0; g < NUM_CLK; g++) begin : g_src
        assign rise_v[g] =  src_i[g] & ~st_q.lvl[g];
        assign drop_v[g] = ~src_i[g] &  st_q.lvl[g];
    end

    always_comb begin
        st_d     = st_q;
        st_d.lvl = src_i;
        fire_o   = fall_i ? drop_v[sel_i] : rise_v[sel_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    input  logic ttype_i,
    input  logic d_i,
    input  logic ctl_en_i,
    input  logic preset_i,
    input  logic reset_i,
    output logic state_o
);
    typedef struct packed {
        logic bit_v;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_en_i && reset_i) begin
            st_d.bit_v = 1'b0;              // clear wins over set
        end else if (ctl_en_i && preset_i) begin
            st_d.bit_v = 1'b1;
        end else if (fire_i) begin
            st_d.bit_v = ttype_i ? (st_q.bit_v ^ d_i) : d_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign state_o = st_q.bit_v;
endmodule

// File: rtl/mc_oe_pick.sv
`timescale 1ns/1ps
module mc_oe_pick #(
    parameter int NUM_OE    = 4,
    localparam int NUM_CODE = NUM_OE + 2,
    localparam int OE_SEL_W = $clog2(NUM_CODE)
) (
    input  logic [NUM_OE-1:0]   terms_i,
    input  logic [OE_SEL_W-1:0] sel_i,
    input  logic                gts_en_i,
    input  logic                gts_ni,
    output logic                oe_o
);
    logic [NUM_CODE-1:0] cand;
    logic                local_oe;

    for (genvar g = 0; g < NUM_OE; g++) begin : g_term
        assign cand[g] = terms_i[g];
    end
    assign cand[NUM_OE]   = 1'b1;           // forced on
    assign cand[NUM_OE+1] = 1'b0;           // forced off

    always_comb begin
        if (int'(sel_i) < NUM_CODE) local_oe = cand[sel_i];
        else                        local_oe = 1'b0;
        oe_o = local_oe & ~(gts_en_i & ~gts_ni);
    end
endmodule

// File: rtl/prog_macrocell.sv
`timescale 1ns/1ps
module prog_macrocell
    import prog_macrocell_pkg::*;
#(
    parameter int NUM_CLK  = MC_NUM_CLK,
    parameter int NUM_OE   = MC_NUM_OE,
    localparam int SEL_W    = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1,
    localparam int OE_SEL_W = $clog2(NUM_OE + 2),
    localparam int CT_W     = MC_OE_BASE + NUM_OE
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cfg_ttype_i,
    input  logic [SEL_W-1:0]    cfg_clksel_i,
    input  logic                cfg_fall_i,
    input  logic                cfg_ctl_en_i,
    input  logic [OE_SEL_W-1:0] cfg_oe_sel_i,
    input  logic                cfg_bypass_i,
    input  logic                cfg_gts_en_i,
    input  logic [NUM_CLK-1:0]  clk_src_i,
    input  logic                d_i,
    input  logic [CT_W-1:0]     ctl_i,
    input  logic                gts_ni,
    input  logic                pad_in_i,
    output logic                pad_o,
    output logic                pad_oe_o,
    output logic                reg_fb_o,
    output logic                pin_fb_o
);
    logic fire;
    logic state;

    mc_edge_pick #(.NUM_CLK(NUM_CLK)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (clk_src_i),
        .sel_i  (cfg_clksel_i),
        .fall_i (cfg_fall_i),
        .fire_o (fire)
    );

    mc_store u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fire_i   (fire),
        .ttype_i  (cfg_ttype_i),
        .d_i      (d_i),
        .ctl_en_i (cfg_ctl_en_i),
        .preset_i (ctl_i[MC_PRESET_BIT]),
        .reset_i  (ctl_i[MC_RESET_BIT]),
        .state_o  (state)
    );

    mc_oe_pick #(.NUM_OE(NUM_OE)) u_oe (
        .terms_i  (ctl_i[CT_W-1:MC_OE_BASE]),
        .sel_i    (cfg_oe_sel_i),
        .gts_en_i (cfg_gts_en_i),
        .gts_ni   (gts_ni),
        .oe_o     (pad_oe_o)
    );

    always_comb begin
        pad_o    = cfg_bypass_i ? d_i : state;
        reg_fb_o = state;
        pin_fb_o = pad_oe_o ? pad_o : pad_in_i;
    end
endmodule

// File: rtl/prog_macrocell_chk.sv
`timescale 1ns/1ps
module prog_macrocell_chk #(
    parameter int NUM_CLK  = 2,
    parameter int NUM_OE   = 4,
    localparam int SEL_W    = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1,
    localparam int OE_SEL_W = $clog2(NUM_OE + 2),
    localparam int CT_W     = 2 + NUM_OE
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                cfg_ttype_i,
    input logic [SEL_W-1:0]    cfg_clksel_i,
    input logic                cfg_fall_i,
    input logic                cfg_ctl_en_i,
    input logic [OE_SEL_W-1:0] cfg_oe_sel_i,
    input logic                cfg_bypass_i,
    input logic                cfg_gts_en_i,
    input logic [NUM_CLK-1:0]  clk_src_i,
    input logic                d_i,
    input logic [CT_W-1:0]     ctl_i,
    input logic                gts_ni,
    input logic                pad_in_i,
    input logic                pad_o,
    input logic                pad_oe_o,
    input logic                reg_fb_o,
    input logic                pin_fb_o
);
    logic [NUM_CLK-1:0] seen_lvl;
    logic               armed;
    logic               cur_lvl, old_lvl, edge_c, ctl_act;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_lvl <= '0;
            armed    <= 1'b0;
        end else begin
            seen_lvl <= clk_src_i;
            armed    <= 1'b1;
        end
    end

    always_comb begin
        cur_lvl = clk_src_i[cfg_clksel_i];
        old_lvl = seen_lvl[cfg_clksel_i];
        edge_c  = cfg_fall_i ? (old_lvl & ~cur_lvl) : (~old_lvl & cur_lvl);
        ctl_act = cfg_ctl_en_i & (ctl_i[0] | ctl_i[1]);
    end

    AST_RESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_ctl_en_i && ctl_i[1]) |=> !reg_fb_o) else $error("reset term"); // R7
    AST_PRESET_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_ctl_en_i && ctl_i[0] && !ctl_i[1]) |=> reg_fb_o) else $error("preset term"); // R6
    AST_D_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && edge_c && !ctl_act && !cfg_ttype_i) |=> (reg_fb_o == $past(d_i))) else $error("d load"); // R2
    AST_T_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && edge_c && !ctl_act && cfg_ttype_i && d_i) |=> (reg_fb_o != $past(reg_fb_o))) else $error("t toggle"); // R3
    AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && !edge_c && !ctl_act) |=> $stable(reg_fb_o)) else $error("spurious update"); // R13
    AST_GTS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_gts_en_i && !gts_ni) |-> !pad_oe_o) else $error("global off"); // R9
    AST_OE_FORCED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(cfg_oe_sel_i) > NUM_OE) |-> !pad_oe_o) else $error("forced off"); // R8
    AST_PIN_FB_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pad_oe_o |-> (pin_fb_o == pad_in_i)) else $error("pin feedback"); // R12
    AST_BYPASS_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_bypass_i |-> (pad_o == d_i)) else $error("bypass"); // R10
endmodule

bind prog_macrocell prog_macrocell_chk #(.NUM_CLK(NUM_CLK), .NUM_OE(NUM_OE)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_ttype_i(cfg_ttype_i), .cfg_clksel_i(cfg_clksel_i),
    .cfg_fall_i(cfg_fall_i), .cfg_ctl_en_i(cfg_ctl_en_i), .cfg_oe_sel_i(cfg_oe_sel_i),
    .cfg_bypass_i(cfg_bypass_i), .cfg_gts_en_i(cfg_gts_en_i), .clk_src_i(clk_src_i),
    .d_i(d_i), .ctl_i(ctl_i), .gts_ni(gts_ni), .pad_in_i(pad_in_i), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .reg_fb_o(reg_fb_o), .pin_fb_o(pin_fb_o)
);

// File: tb/prog_macrocell_test.sv
`timescale 1ns/1ps
module prog_macrocell_test;
    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;   // 125 MHz

    // signals driven into the design
    logic       u_ttype, u_clksel, u_fall, u_ctl_en, u_bypass, u_gts_en;
    logic [2:0] u_oe_sel;
    logic [1:0] u_src;
    logic       u_d, u_gts_n, u_pad_in;
    logic [5:0] u_ctl;
    // staged configuration, applied inside step
    logic       s_ttype, s_clksel, s_fall, s_ctl_en, s_bypass, s_gts_en;
    logic [2:0] s_oe_sel;

    logic pad_o, pad_oe_o, reg_fb_o, pin_fb_o;

    prog_macrocell uut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_ttype_i(u_ttype), .cfg_clksel_i(u_clksel),
        .cfg_fall_i(u_fall), .cfg_ctl_en_i(u_ctl_en), .cfg_oe_sel_i(u_oe_sel),
        .cfg_bypass_i(u_bypass), .cfg_gts_en_i(u_gts_en), .clk_src_i(u_src),
        .d_i(u_d), .ctl_i(u_ctl), .gts_ni(u_gts_n), .pad_in_i(u_pad_in),
        .pad_o(pad_o), .pad_oe_o(pad_oe_o), .reg_fb_o(reg_fb_o), .pin_fb_o(pin_fb_o)
    );

    typedef struct {
        logic  e_reg, e_oe, e_pad, e_pin;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    logic       m_reg = 1'b0;
    logic [1:0] m_prev = 2'b00;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the outputs it must produce
    task automatic step(input logic [1:0] src, input logic d, input logic [5:0] ctl,
                        input logic gts_n, input logic pad_in, input string tag);
        logic sel_now, sel_old, fire, loc_oe, oe, pv;
        exp_t e;
        @(negedge clk);
        u_ttype = s_ttype; u_clksel = s_clksel; u_fall = s_fall; u_ctl_en = s_ctl_en;
        u_bypass = s_bypass; u_gts_en = s_gts_en; u_oe_sel = s_oe_sel;
        u_src = src; u_d = d; u_ctl = ctl; u_gts_n = gts_n; u_pad_in = pad_in;
        sel_now = src[s_clksel];
        sel_old = m_prev[s_clksel];
        fire = s_fall ? (sel_old & ~sel_now) : (~sel_old & sel_now);
        if (s_ctl_en && ctl[1])      m_reg = 1'b0;
        else if (s_ctl_en && ctl[0]) m_reg = 1'b1;
        else if (fire)               m_reg = s_ttype ? (m_reg ^ d) : d;
        m_prev = src;
        loc_oe = (s_oe_sel < 3'd4) ? ctl[2 + int'(s_oe_sel)] : (s_oe_sel == 3'd4);
        oe = loc_oe & ~(s_gts_en & ~gts_n);
        pv = s_bypass ? d : m_reg;
        e.e_reg = m_reg; e.e_oe = oe; e.e_pad = pv; e.e_pin = oe ? pv : pad_in; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "reg_fb_o", reg_fb_o, e.e_reg);
                chk(e.tag, "pad_oe_o", pad_oe_o, e.e_oe);
                chk(e.tag, "pad_o", pad_o, e.e_pad);
                chk(e.tag, "pin_fb_o", pin_fb_o, e.e_pin);
            end
        end
    end

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        s_ttype = 0; s_clksel = 0; s_fall = 0; s_ctl_en = 0; s_bypass = 0; s_gts_en = 0;
        s_oe_sel = 3'd4;
        u_ttype = 0; u_clksel = 0; u_fall = 0; u_ctl_en = 0; u_bypass = 0; u_gts_en = 0;
        u_oe_sel = 3'd4; u_src = 2'b00; u_d = 1'b1; u_ctl = 6'b000011; u_gts_n = 1; u_pad_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reg_fb_o in reset", reg_fb_o, 1'b0);
        rst_n = 1'b1;

        // R1: idle after release
        step(2'b00, 0, 6'b0, 1, 0, "R1");
        step(2'b00, 1, 6'b0, 1, 0, "R1");
        // R2: D load on rising edge of source 0, nothing on the fall
        step(2'b01, 1, 6'b0, 1, 0, "R2");
        step(2'b00, 0, 6'b0, 1, 0, "R2");
        step(2'b01, 0, 6'b0, 1, 0, "R2");
        step(2'b00, 1, 6'b0, 1, 0, "R2");
        // R4: source 1 ignored while source 0 is selected, then used
        step(2'b10, 1, 6'b0, 1, 0, "R4");
        step(2'b00, 1, 6'b0, 1, 0, "R4");
        s_clksel = 1;
        step(2'b00, 1, 6'b0, 1, 0, "R4");
        step(2'b10, 1, 6'b0, 1, 0, "R4");
        step(2'b11, 0, 6'b0, 1, 0, "R4");
        step(2'b01, 0, 6'b0, 1, 0, "R4");
        // R13: switching selection with sources at different levels
        step(2'b01, 1, 6'b0, 1, 0, "R13");
        s_clksel = 0;
        step(2'b01, 1, 6'b0, 1, 0, "R13");
        s_fall = 1;
        step(2'b01, 1, 6'b0, 1, 0, "R13");
        // R5: falling edge mode
        step(2'b00, 1, 6'b0, 1, 0, "R5");
        step(2'b01, 0, 6'b0, 1, 0, "R5");
        step(2'b00, 0, 6'b0, 1, 0, "R5");
        step(2'b01, 1, 6'b0, 1, 0, "R5");
        step(2'b00, 1, 6'b0, 1, 0, "R5");
        // R3: T mode toggles on d=1, holds on d=0
        s_fall = 0; s_ttype = 1;
        step(2'b01, 1, 6'b0, 1, 0, "R3");
        step(2'b00, 1, 6'b0, 1, 0, "R3");
        step(2'b01, 1, 6'b0, 1, 0, "R3");
        step(2'b00, 0, 6'b0, 1, 0, "R3");
        step(2'b01, 0, 6'b0, 1, 0, "R3");
        step(2'b00, 1, 6'b0, 1, 0, "R3");
        // R6: control-term set and clear, and ignored when disabled
        s_ttype = 0; s_ctl_en = 1;
        step(2'b00, 0, 6'b000010, 1, 0, "R6");
        step(2'b00, 0, 6'b000001, 1, 0, "R6");
        step(2'b00, 0, 6'b000000, 1, 0, "R6");
        s_ctl_en = 0;
        step(2'b00, 0, 6'b000010, 1, 0, "R6");
        step(2'b00, 1, 6'b000000, 1, 0, "R6");
        // R7: clear wins
        s_ctl_en = 1;
        step(2'b00, 1, 6'b000011, 1, 0, "R7");
        step(2'b00, 1, 6'b000001, 1, 0, "R7");
        step(2'b00, 1, 6'b000011, 1, 0, "R7");
        s_ctl_en = 0;
        // R8: every enable code with two term patterns
        for (int sel = 0; sel < 8; sel++) begin
            s_oe_sel = 3'(sel);
            step(2'b00, 0, 6'b111100, 1, 1, "R8");
            step(2'b00, 0, 6'b000000, 1, 1, "R8");
            step(2'b00, 0, {4'(1 << (sel % 4)), 2'b00}, 1, 1, "R8");
        end
        // R9: global three-state
        s_oe_sel = 3'd4; s_gts_en = 1;
        step(2'b00, 0, 6'b0, 0, 1, "R9");
        step(2'b00, 0, 6'b0, 1, 1, "R9");
        s_gts_en = 0;
        step(2'b00, 0, 6'b0, 0, 1, "R9");
        // R12: pin feedback follows external value when disabled
        step(2'b01, 1, 6'b0, 1, 0, "R12");
        s_oe_sel = 3'd5;
        step(2'b00, 1, 6'b0, 1, 0, "R12");
        step(2'b00, 1, 6'b0, 1, 1, "R12");
        step(2'b00, 0, 6'b0, 1, 0, "R12");
        // R10 / R11: bypass drives d_i, register feedback unaffected
        s_oe_sel = 3'd4; s_bypass = 1;
        step(2'b00, 0, 6'b0, 1, 0, "R10");
        step(2'b00, 1, 6'b0, 1, 0, "R10");
        step(2'b01, 0, 6'b0, 1, 1, "R11");
        step(2'b00, 1, 6'b0, 1, 1, "R11");
        s_oe_sel = 3'd6;
        step(2'b00, 0, 6'b0, 1, 1, "R11");

        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule